// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside a small processor core and decides when the core leaves its program to serve an interrupt. It watches 21 request lines, each gated by its own local enable, plus one global enable held inside the block. When the core signals that an instruction has finished, the global enable is set, and at least one enabled request is pending, the block takes the lowest-numbered such request. In that same cycle it pulses a take-vector strobe with the vector number and vector address. It also pulses a strobe asking the core to push its return address, and sends a one-hot acknowledge back to the chosen source so that the source can drop its pending flag.

After an acceptance, further interrupts are locked out because the global enable is cleared. A set-enable strobe or a return-from-interrupt strobe from the core sets the enable again. The return strobe also produces a resume pulse toward the core. Line 0 is the reset request. It is served in any cycle, ignores every enable and does not ask for a return address to be pushed.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While and right after reset, the global enable output is 0, no take-vector, push or resume strobe is asserted, and all acknowledge bits are 0 when no request is driven.
- R2: A set-enable strobe with no acceptance in the same cycle makes the global enable read 1 from the next cycle on.
- R3: A request on lines 1 to 20 is accepted only in a cycle where instruction-done is high, the global enable is 1, and that line's local enable is 1. Otherwise no take-vector strobe is produced.
- R4: Among pending requests whose local enable is set, the lowest line index wins.
- R5: The vector number output equals the winning line index. The vector address equals index times 2 plus a base of 0.
- R6: For a non-reset acceptance, the push-return-address strobe is high in the same cycle as the take-vector strobe. It is low in every other cycle.
- R7: Any acceptance makes the global enable read 0 in the next cycle. This holds even when a set-enable or return strobe arrives in the same cycle.
- R8: A return strobe with no acceptance in the same cycle sets the global enable for the next cycle and raises the resume output in that same cycle. The resume output is 0 in a cycle with an acceptance.
- R9: The acknowledge vector is one-hot at the winning index during the take-vector cycle and all zero otherwise.
- R10: A request on line 0 is accepted in any cycle, regardless of instruction-done, global enable or its local enable, with vector 0 and no push strobe. It outranks every other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 21 | Pending request per line; line 0 is the reset request |
| irq_en | input | 21 | Local enable per line (ignored for line 0) |
| sei_i | input | 1 | Set-global-enable strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| insn_done_i | input | 1 | Instruction completion strobe |
| take_o | output | 1 | Take-vector strobe |
| push_ret_o | output | 1 | Push-return-address strobe |
| vec_num_o | output | 5 | Accepted vector number |
| vec_addr_o | output | 16 | Accepted vector address |
| ack_o | output | 21 | One-hot acknowledge to the accepted source |
| resume_o | output | 1 | Resume-at-saved-address strobe |
| gie_o | output | 1 | Current global enable |

## Verification
Acceptance and a write to the global enable can land in the same cycle. A set-enable or return strobe may coincide with an instruction-done that accepts a request, and a return strobe may coincide with a reset request. The bench provokes each collision by driving both inputs in one cycle. It judges the result by reading the global enable one cycle later, where it must be 0, and by checking that resume stays low in the accepting cycle.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N      = 21,
  parameter int ADDR_W = 16,
  parameter int STRIDE = 2,
  parameter int BASE   = 0,
  localparam int VEC_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_req,
  input  logic [N-1:0]      irq_en,
  input  logic              sei_i,
  input  logic              reti_i,
  input  logic              insn_done_i,
  output logic              take_o,
  output logic              push_ret_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [N-1:0]      ack_o,
  output logic              resume_o,
  output logic              gie_o
);

  logic             gie_q;
  logic [N-1:0]     live;
  logic [VEC_W-1:0] sel;
  logic             any_live, rst_req, accept;

  assign rst_req = irq_req[0];
  assign live    = {irq_req[N-1:1] & irq_en[N-1:1], 1'b0};

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 1; i--)
      if (live[i]) sel = VEC_W'(i);
  end

  assign any_live   = |live;
  assign accept     = rst_req | (insn_done_i & gie_q & any_live);

  assign take_o     = accept;
  assign push_ret_o = accept & ~rst_req;
  assign vec_num_o  = rst_req ? '0 : sel;
  assign vec_addr_o = ADDR_W'(BASE) + ADDR_W'(vec_num_o) * ADDR_W'(STRIDE);
  assign ack_o      = accept ? (N'(1) << vec_num_o) : '0;
  assign resume_o   = reti_i & ~accept;
  assign gie_o      = gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gie_q <= 1'b0;
    else if (accept)          gie_q <= 1'b0;
    else if (sei_i | reti_i)  gie_q <= 1'b1;
  end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N = 21,
  localparam int VEC_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     irq_req,
  input logic [N-1:0]     irq_en,
  input logic             sei_i,
  input logic             reti_i,
  input logic             insn_done_i,
  input logic             take_o,
  input logic             push_ret_o,
  input logic [VEC_W-1:0] vec_num_o,
  input logic [N-1:0]     ack_o,
  input logic             resume_o,
  input logic             gie_o
);

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !irq_req[0]) |-> (insn_done_i && gie_o && irq_en[vec_num_o] && irq_req[vec_num_o]));

  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !irq_req[0]) |-> (((irq_req & irq_en) & ((N'(1) << vec_num_o) - N'(1))) == '0));

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret_o |-> (take_o && vec_num_o != '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o);

  p_reti_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_o) |=> gie_o);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o) && (take_o == (ack_o != '0)));

  p_rstreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> (take_o && vec_num_o == '0 && !push_ret_o && !resume_o));

  p_sei_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sei_i && !take_o) |=> gie_o);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N)) chk_i (.*);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  localparam int N = 21;
  localparam int NV = 10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic sei_i = 0, reti_i = 0, insn_done_i = 0;
  logic take_o, push_ret_o, resume_o, gie_o;
  logic [4:0] vec_num_o;
  logic [15:0] vec_addr_o;
  logic [N-1:0] ack_o;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (.*);

  // {req, en, gie_pre, done, exp_take, exp_vec}
  localparam logic [49:0] VT [NV] = '{
    {21'h000008, 21'h000008, 1'b1, 1'b1, 1'b1, 5'd3},
    {21'h000008, 21'h000000, 1'b1, 1'b1, 1'b0, 5'd0},
    {21'h000008, 21'h000008, 1'b0, 1'b1, 1'b0, 5'd0},
    {21'h000008, 21'h000008, 1'b1, 1'b0, 1'b0, 5'd0},
    {21'h000220, 21'h1FFFFF, 1'b1, 1'b1, 1'b1, 5'd5},
    {21'h000220, 21'h000200, 1'b1, 1'b1, 1'b1, 5'd9},
    {21'h100000, 21'h1FFFFF, 1'b1, 1'b1, 1'b1, 5'd20},
    {21'h000006, 21'h1FFFFF, 1'b1, 1'b1, 1'b1, 5'd1},
    {21'h000001, 21'h000000, 1'b0, 1'b0, 1'b1, 5'd0},
    {21'h000011, 21'h1FFFFF, 1'b1, 1'b1, 1'b1, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; irq_req = '0; irq_en = '0; sei_i = 0; reti_i = 0; insn_done_i = 0;
    cyc(); rst_n = 1; cyc();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    #1;
    chk("R1 gie", 32'(gie_o), 0);
    chk("R1 take", 32'(take_o), 0);
    chk("R1 push", 32'(push_ret_o), 0);
    chk("R1 resume", 32'(resume_o), 0);
    chk("R1 ack", 32'(ack_o), 0);

    for (int k = 0; k < NV; k++) begin
      logic [20:0] r, e; logic g, d, et; logic [4:0] ev;
      {r, e, g, d, et, ev} = VT[k];
      do_reset();
      if (g) begin sei_i = 1; cyc(); sei_i = 0; end
      irq_req = r; irq_en = e; insn_done_i = d;
      #1;
      chk("R3 take", 32'(take_o), 32'(et));
      if (et) begin
        chk("R4 vec", 32'(vec_num_o), 32'(ev));
        chk("R5 addr", 32'(vec_addr_o), 32'(ev) * 2);
      end
      chk("R9 ack", 32'(ack_o), et ? (32'(1) << ev) : 0);
      chk("R6 push", 32'(push_ret_o), 32'(et && ev != 0));
      @(posedge clk); #1;
      chk("R7 gie after", 32'(gie_o), 32'(et ? 1'b0 : g));
      @(negedge clk);
      irq_req = '0; irq_en = '0; insn_done_i = 0;
    end

    // R2: set-enable
    do_reset();
    sei_i = 1; #1;
    chk("R2 gie before edge", 32'(gie_o), 0);
    cyc(); sei_i = 0;
    chk("R2 gie set", 32'(gie_o), 1);

    // R8: return strobe from cleared state
    do_reset();
    reti_i = 1; #1;
    chk("R8 resume", 32'(resume_o), 1);
    cyc(); reti_i = 0; #1;
    chk("R8 gie", 32'(gie_o), 1);
    chk("R8 resume low", 32'(resume_o), 0);

    // R7 collision: sei with acceptance
    do_reset();
    sei_i = 1; cyc();
    irq_req = 21'h000080; irq_en = 21'h000080; insn_done_i = 1; #1;
    chk("R7 take in collision", 32'(take_o), 1);
    cyc(); sei_i = 0; irq_req = '0; insn_done_i = 0; #1;
    chk("R7 sei+accept gie", 32'(gie_o), 0);

    // R7/R8 collision: reti with reset request
    do_reset();
    sei_i = 1; cyc(); sei_i = 0;
    reti_i = 1; irq_req = 21'h000001; #1;
    chk("R8 resume blocked", 32'(resume_o), 0);
    chk("R10 take", 32'(take_o), 1);
    chk("R10 push", 32'(push_ret_o), 0);
    cyc(); reti_i = 0; irq_req = '0; #1;
    chk("R7 reti+accept gie", 32'(gie_o), 0);

    // R3: after acceptance, a second request is held off until re-enable
    do_reset();
    sei_i = 1; cyc(); sei_i = 0;
    irq_req = 21'h000004; irq_en = 21'h000004; insn_done_i = 1; cyc(); #1;
    chk("R3 no nested take", 32'(take_o), 0);
    reti_i = 1; cyc(); reti_i = 0; #1;
    chk("R3 take after return", 32'(take_o), 1);
    chk("R5 addr after return", 32'(vec_addr_o), 4);
    cyc(); irq_req = '0; insn_done_i = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule